// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM with a burst address counter and a read path that is two registers deep. A host starts an access in one of two ways. The processor-side strobe always starts a read. The controller-side strobe can start either a read or a write, depending on the write enables sampled on the same edge. Once a burst is open, the advance input either moves the access to the next address of a four-beat group or holds it on the current address. On each edge of an open burst, the write enables choose between a read and a write.

Writes can cover the whole word or only chosen byte lanes. Each lane is nine bits wide: eight data bits and one parity bit. Read data leaves through two register stages. An output enable gates the data combinationally and does not touch the pipeline. A sleep input turns the outputs off at once and keeps the array and the burst position. After sleep ends, the block ignores a fixed number of clock edges before it resumes. Data in, data out and the output-drive flag are separate ports; there is no tristate bus.

Top module: `pipe_burst_sram`

## Requirements
- R1: After a synchronous reset, `rdata_oe` is low and `rdata` is zero until a new read has passed through the pipeline. The reset does not clear the array.
- R2: The block counts as selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. With `sel1_n` high, a low `strb_cpu_n` is ignored. Any strobe taken while the block is not selected closes the open burst, and no access happens on that edge.
- R3: When `strb_cpu_n` is low, `sel1_n` is low and the block is selected, a read burst opens at `addr`. On that edge the write enables and `strb_ctl_n` are ignored.
- R4: `strb_ctl_n` low opens a burst at `addr` only when the processor strobe is not in effect. The write enables are sampled on that same edge, so a write to `addr` can happen there.
- R5: A read sampled on edge k appears on `rdata` after edge k+1, with `rdata_oe` high when `oe_n` is low.
- R6: `wr_all_n`=0 writes all lanes. Otherwise lane b, which is bits [9b+8:9b] with bit 9b+8 as its parity bit, is written only when `wr_byte_n`=0 and `lane_n[b]`=0. If no lane is enabled, the edge is a read.
- R7: On an edge that samples a write, `rdata_oe` goes low from that edge onward, whatever `oe_n` is.
- R8: On an edge with both strobes high and a burst open, `adv_n`=0 steps to the next address and `adv_n`=1 stays on the current one. By default the order is linear: the two low address bits count up and wrap inside the aligned group of four, so a burst from 5 runs 5, 6, 7, 4.
- R9: `sleep` high forces `rdata_oe` low at once and blocks every access. The array and the burst position are kept. The first two edges after `sleep` falls are also ignored.
- R10: `oe_n` only gates the outputs. Data read while `oe_n` was high is still shown when `oe_n` goes low, if the data is still in the output register.
- R11: Edges with both strobes high and no open burst cause no read and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every control except `oe_n` and `sleep` is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Start address of a new burst |
| sel1_n | input | 1 | Select, active low; also gates the processor strobe |
| sel2 | input | 1 | Select, active high |
| sel3_n | input | 1 | Select, active low |
| strb_cpu_n | input | 1 | Processor-side start strobe, active low, read only |
| strb_ctl_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_byte_n | input | 1 | Enables the per-lane write enables, active low |
| lane_n | input | BYTES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| wdata | input | BYTES*LANE_W | Write data |
| rdata | output | BYTES*LANE_W | Read data, zero while not driven |
| rdata_oe | output | 1 | High while `rdata` is driven |

## Verification
A read sampled on one edge is due on `rdata` after the next edge. A write mutes the outputs right after the edge that samples it. Sleep mutes them with no clock at all, and the two edges after sleep falls must show no effect. The bench's reference model steps on each rising edge and keeps the two pipeline stages as plain variables. It compares both outputs at every falling edge, so each result is checked in the exact cycle it is due. Directed checks also read back known words after a burst, after deselected writes and after sleep.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_DESEL = 2'd1,
      OP_READ  = 2'd2,
      OP_WRITE = 2'd3
   } pbr_op_e;
endpackage

// File: rtl/pbr_start_arb.sv
module pbr_start_arb
   import pbr_pkg::*;
#(
   parameter int BYTES = 4
) (
   input  logic             hold,
   input  logic             active,
   input  logic             sel1_n,
   input  logic             sel2,
   input  logic             sel3_n,
   input  logic             strb_cpu_n,
   input  logic             strb_ctl_n,
   input  logic             adv_n,
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [BYTES-1:0] lane_n,
   output pbr_op_e          op,
   output logic             load,
   output logic             step,
   output logic [BYTES-1:0] wmask
);
   logic             picked;
   logic             cpu_go;
   logic [BYTES-1:0] lanes;

   always_comb begin
      picked = !sel1_n && sel2 && !sel3_n;
      cpu_go = !strb_cpu_n && !sel1_n;
      lanes  = wr_all_n ? (~lane_n & {BYTES{~wr_byte_n}}) : {BYTES{1'b1}};
      op     = OP_IDLE;
      load   = 1'b0;
      step   = 1'b0;
      wmask  = '0;
      if (!hold) begin
         if (cpu_go) begin
            if (picked) begin
               load = 1'b1;
               op   = OP_READ;
            end else begin
               op = OP_DESEL;
            end
         end else if (!strb_ctl_n) begin
            if (picked) begin
               load = 1'b1;
               if (|lanes) begin
                  op    = OP_WRITE;
                  wmask = lanes;
               end else begin
                  op = OP_READ;
               end
            end else begin
               op = OP_DESEL;
            end
         end else if (active) begin
            step = !adv_n;
            if (|lanes) begin
               op    = OP_WRITE;
               wmask = lanes;
            end else begin
               op = OP_READ;
            end
         end
      end
   end
endmodule

// File: rtl/pbr_burst_ctr.sv
module pbr_burst_ctr #(
   parameter int ADDR_W    = 6,
   parameter int BURST_W   = 2,
   parameter bit BURST_ILV = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              step,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] acc_addr
);
   logic [ADDR_W-1:0]  base_q, base_n;
   logic [BURST_W-1:0] cnt_q, cnt_n, offs;
   logic               seen_q;

   always_comb begin
      base_n = load ? ext_addr : base_q;
      cnt_n  = load ? '0 : (step ? cnt_q + 1'b1 : cnt_q);
   end

   generate
      if (BURST_ILV) begin : g_ilv
         assign offs = base_n[BURST_W-1:0] ^ cnt_n;
      end else begin : g_lin
         assign offs = base_n[BURST_W-1:0] + cnt_n;
      end
   endgenerate

   assign acc_addr = {base_n[ADDR_W-1:BURST_W], offs};

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         base_q <= base_n;
         cnt_q  <= cnt_n;
         seen_q <= 1'b1;
      end
   end

   // R8
   suspend_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (seen_q && !load && !step) |-> acc_addr == $past(acc_addr));
endmodule

// File: rtl/pbr_array.sv
module pbr_array #(
   parameter int ADDR_W = 6,
   parameter int BYTES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      re,
   input  logic [BYTES-1:0]          we,
   input  logic [BYTES*LANE_W-1:0]   wdata,
   output logic [BYTES*LANE_W-1:0]   rd_q
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int DATA_W = BYTES * LANE_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (re) rd_q <= mem[addr];
      for (int b = 0; b < BYTES; b++) begin
         if (we[b]) mem[addr][b*LANE_W +: LANE_W] <= wdata[b*LANE_W +: LANE_W];
      end
   end
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
   import pbr_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int BYTES     = 4,
   parameter int LANE_W    = 9,
   parameter int BURST_W   = 2,
   parameter bit BURST_ILV = 1'b0,
   parameter int WAKE_CYC  = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    sel1_n,
   input  logic                    sel2,
   input  logic                    sel3_n,
   input  logic                    strb_cpu_n,
   input  logic                    strb_ctl_n,
   input  logic                    adv_n,
   input  logic                    wr_all_n,
   input  logic                    wr_byte_n,
   input  logic [BYTES-1:0]        lane_n,
   input  logic                    oe_n,
   input  logic                    sleep,
   input  logic [BYTES*LANE_W-1:0] wdata,
   output logic [BYTES*LANE_W-1:0] rdata,
   output logic                    rdata_oe
);
   localparam int DATA_W = BYTES * LANE_W;
   localparam int WAKE_W = $clog2(WAKE_CYC + 1);

   generate
      if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
         $error("BURST_W must be at least 1 and below ADDR_W");
      end
      if (WAKE_CYC < 1) begin : g_bad_wake
         $error("WAKE_CYC must be at least 1");
      end
      if (BYTES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("BYTES and LANE_W must be positive");
      end
   endgenerate

   pbr_op_e           op;
   logic              load, step, hold;
   logic [BYTES-1:0]  wmask;
   logic [ADDR_W-1:0] acc_addr;
   logic [DATA_W-1:0] arr_q, out_q;
   logic [WAKE_W-1:0] wake_q;
   logic              active_q, v1_q, out_v_q;
   logic [1:0]        age_q;

   assign hold = sleep || (wake_q != '0);

   pbr_start_arb #(.BYTES(BYTES)) u_arb (
      .hold(hold), .active(active_q), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
      .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n),
      .op(op), .load(load), .step(step), .wmask(wmask));

   pbr_burst_ctr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .BURST_ILV(BURST_ILV)) u_ctr (
      .clk(clk), .rst(rst), .load(load), .step(step), .ext_addr(addr), .acc_addr(acc_addr));

   pbr_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .LANE_W(LANE_W)) u_arr (
      .clk(clk), .addr(acc_addr), .re(op == OP_READ), .we(wmask), .wdata(wdata), .rd_q(arr_q));

   always_ff @(posedge clk) begin
      if (rst) begin
         wake_q   <= '0;
         active_q <= 1'b0;
         v1_q     <= 1'b0;
         out_v_q  <= 1'b0;
         out_q    <= '0;
         age_q    <= '0;
      end else begin
         if (sleep)               wake_q <= WAKE_W'(WAKE_CYC);
         else if (wake_q != '0)   wake_q <= wake_q - 1'b1;
         if (load)                active_q <= 1'b1;
         else if (op == OP_DESEL) active_q <= 1'b0;
         v1_q    <= (op == OP_READ);
         out_v_q <= v1_q && (op != OP_WRITE);
         if (v1_q) out_q <= arr_q;
         if (age_q != 2'd3) age_q <= age_q + 1'b1;
      end
   end

   assign rdata_oe = out_v_q && !oe_n && !sleep;
   assign rdata    = rdata_oe ? out_q : '0;

   // R7
   write_mutes_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_WRITE) |=> !rdata_oe);
   // R5
   pipe_depth_chk: assert property (@(posedge clk) disable iff (rst)
      (age_q == 2'd3 && $rose(out_v_q)) |-> $past(op, 2) == OP_READ);
   // R9
   wake_block_chk: assert property (@(posedge clk) disable iff (rst)
      (age_q != 2'd0 && $past(sleep) && !sleep) |-> op == OP_IDLE);
   // R11
   idle_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
      (!active_q && !load) |-> wmask == '0);
endmodule

// File: tb/sim_pipe_burst_sram.sv
module sim_pipe_burst_sram;
   localparam int AW = 6, NB = 4, LW = 9, DW = NB * LW, DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #2.5ns clk = ~clk;

   logic          rst, sel1_n, sel2, sel3_n, strb_cpu_n, strb_ctl_n, adv_n;
   logic          wr_all_n, wr_byte_n, oe_n, sleep;
   logic [AW-1:0] addr;
   logic [NB-1:0] lane_n;
   logic [DW-1:0] wdata, rdata;
   logic          rdata_oe;

   pipe_burst_sram u0 (
      .clk(clk), .rst(rst), .addr(addr), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
      .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_n(lane_n), .oe_n(oe_n),
      .sleep(sleep), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe));

   int    errs = 0, checks = 0;
   bit    done = 1'b0;
   string cur_req = "R1 reset";

   // reference model state
   logic [DW-1:0] rmem [DEPTH];
   logic [DW-1:0] p1d, p2d;
   bit            p1v, p2v, m_act, m_hold, m_sel, m_rd, m_wr;
   int            m_base, m_cnt, m_wake, m_a;
   logic [NB-1:0] m_lane;

   function automatic logic [DW-1:0] pat(int a);
      return (DW'(a) * 36'h00F1E3) ^ 36'h9A5C31E0F;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_act = 0; m_base = 0; m_cnt = 0; m_wake = 0; p1v = 0; p2v = 0; p2d = '0;
      end else begin
         m_hold = sleep || (m_wake > 0);
         if (sleep) m_wake = 2;
         else if (m_wake > 0) m_wake = m_wake - 1;
         for (int b = 0; b < NB; b++) m_lane[b] = !wr_all_n || (!wr_byte_n && !lane_n[b]);
         m_rd = 0; m_wr = 0;
         m_sel = !sel1_n && sel2 && !sel3_n;
         if (!m_hold) begin
            if (!strb_cpu_n && !sel1_n) begin
               if (m_sel) begin m_act = 1; m_base = int'(addr); m_cnt = 0; m_rd = 1; end
               else m_act = 0;
            end else if (!strb_ctl_n) begin
               if (m_sel) begin
                  m_act = 1; m_base = int'(addr); m_cnt = 0;
                  if (m_lane != 0) m_wr = 1; else m_rd = 1;
               end else m_act = 0;
            end else if (m_act) begin
               if (!adv_n) m_cnt = (m_cnt + 1) % 4;
               if (m_lane != 0) m_wr = 1; else m_rd = 1;
            end
         end
         m_a = (m_base & ~3) | ((m_base + m_cnt) & 3);
         p2v = m_wr ? 1'b0 : p1v;
         if (p1v) p2d = p1d;
         p1v = m_rd;
         if (m_rd) p1d = rmem[m_a];
         if (m_wr)
            for (int b = 0; b < NB; b++)
               if (m_lane[b]) rmem[m_a][b*LW +: LW] = wdata[b*LW +: LW];
      end
   end

   always @(negedge clk) begin
      if (!rst && !done) begin
         logic          e_oe;
         logic [DW-1:0] e_d;
         e_oe = p2v && !oe_n && !sleep;
         e_d  = e_oe ? p2d : '0;
         checks++;
         if (rdata_oe !== e_oe || rdata !== e_d) begin
            errs++;
            $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", cur_req, rdata_oe, rdata, e_oe, e_d);
         end
      end
   end

   task automatic tick(int n = 1);
      repeat (n) begin @(negedge clk); #1ns; end
   endtask

   task automatic set_idle();
      sel1_n = 0; sel2 = 1; sel3_n = 0; strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
      wr_all_n = 1; wr_byte_n = 1; lane_n = '1; oe_n = 0; sleep = 0; addr = '0; wdata = '0;
   endtask

   task automatic dchk(string req, logic [DW-1:0] exp);
      checks++;
      if (!(rdata_oe === 1'b1 && rdata === exp)) begin
         errs++;
         $display("FAIL %s: oe=%b data=%h expected oe=1 data=%h", req, rdata_oe, rdata, exp);
      end
   endtask

   task automatic cpu_read(int a);
      strb_cpu_n = 0; addr = AW'(a); tick; set_idle;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: run did not end, expected end before timeout");
      finish_run();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) rmem[i] = '0;
      set_idle; rst = 1; tick(3);
      rst = 0; tick;
      checks++;
      if (rdata_oe !== 1'b0) begin
         errs++; $display("FAIL R1: oe=%b expected oe=0", rdata_oe);
      end

      cur_req = "R4 controller-strobe writes";
      for (int a = 0; a < 32; a++) begin
         strb_ctl_n = 0; addr = AW'(a); wr_all_n = 0; wdata = pat(a); tick;
      end
      set_idle; tick(2);

      cur_req = "R3 processor strobe read, writes ignored";
      strb_cpu_n = 0; strb_ctl_n = 0; wr_all_n = 0; addr = 6'd5; wdata = '1; tick;
      set_idle; tick;
      dchk("R5 latency", pat(5));
      cur_req = "R8 linear advance";
      adv_n = 0; tick(3); set_idle; tick(2);

      cur_req = "R8 suspend and continue";
      strb_ctl_n = 0; addr = 6'd10; tick; set_idle;
      adv_n = 0; tick; adv_n = 1; tick(2); adv_n = 0; tick(2); set_idle; tick(2);

      cur_req = "R6 byte lanes";
      strb_ctl_n = 0; addr = 6'd12; wr_byte_n = 0; lane_n = 4'b1110; wdata = '0; tick;
      addr = 6'd13; lane_n = 4'b0101; wdata = 36'hFFFFFFFFF; tick;
      addr = 6'd14; wr_byte_n = 1; lane_n = 4'b0000; wdata = '0; tick;
      addr = 6'd15; wr_all_n = 0; lane_n = 4'b1111; wdata = 36'h123456789; tick;
      set_idle; cpu_read(12); adv_n = 0; tick(3); set_idle; tick(2);

      cur_req = "R4 burst write after processor strobe";
      cpu_read(20);
      wr_all_n = 0; wdata = 36'h0DEADBEEF; tick;
      adv_n = 0; wdata = 36'h0CAFEF00D; tick;
      wr_all_n = 1; wr_byte_n = 0; lane_n = 4'b0011; wdata = 36'h0; tick;
      set_idle; tick; cpu_read(20); adv_n = 0; tick(3); set_idle; tick(2);

      cur_req = "R2 select gating";
      cpu_read(24);
      sel1_n = 1; strb_cpu_n = 0; adv_n = 0; tick(2);
      strb_cpu_n = 1; strb_ctl_n = 0; tick;
      cur_req = "R11 no burst open";
      strb_ctl_n = 1; sel1_n = 0; wr_all_n = 0; wdata = '0; adv_n = 0; tick(3);
      set_idle;
      cur_req = "R2 deselected strobes";
      strb_cpu_n = 0; sel2 = 0; addr = 6'd28; tick;
      strb_cpu_n = 1; sel2 = 1; sel3_n = 1; strb_ctl_n = 0; wr_all_n = 0; wdata = '0; tick;
      set_idle; tick; cpu_read(24); adv_n = 0; tick(3); set_idle; tick(2);
      cpu_read(28); tick;
      dchk("R2 deselected write", pat(28));

      cur_req = "R3 both strobes low";
      strb_cpu_n = 0; strb_ctl_n = 0; wr_all_n = 0; addr = 6'd29; wdata = '0; tick;
      set_idle; tick; dchk("R3 processor wins", pat(29)); tick;

      cur_req = "R10 output enable gating";
      cpu_read(0); adv_n = 0; oe_n = 1; tick; oe_n = 0; tick; oe_n = 1; tick; oe_n = 0; tick;
      set_idle; tick(2);

      cur_req = "R7 write mutes output";
      strb_ctl_n = 0; addr = 6'd1; tick;
      addr = 6'd2; wr_all_n = 0; wdata = 36'h0AAAA5555; tick;
      set_idle; tick(2);

      cur_req = "R9 sleep and wake";
      cpu_read(8); adv_n = 0; tick;
      sleep = 1; adv_n = 1; strb_ctl_n = 0; wr_all_n = 0; addr = 6'd9; wdata = '0; tick(2);
      sleep = 0; tick(2);
      set_idle; adv_n = 0; tick(3); set_idle; tick(2);
      cpu_read(9); tick;
      dchk("R9 array kept", pat(9));
      tick(2);
      finish_run();
   end
endmodule